// File: doc/BRIEF.md
# Speculative Alias-Check Queue Controller

This block collects a few small address-compare banks, a 256-entry table of per-group speculation statistics, and the decoder for the operations that drive them. Software puts each memory speculation group in the table. An init operation binds one bank to a group: the bank takes the group's use count, failure count and rollback mask from the table. Speculative memory operations name a bank. Each one either records its hashed address in that bank, or checks the address against the addresses the bank already holds. A matching check raises a rollback indication and returns the rollback mask of the group bound to that bank.

A clear operation ends one pass through a speculation region. It forgets the addresses the bank has recorded and increments the group's use count. On the following cycle the updated statistics are written back to the table. A separate software port reads and writes table entries, so an optimizer can seed groups and inspect how often they alias. If an operation is malformed, or names a bank that cannot accept it, the block ignores it and pulses an error flag.

Top module: `spec_alias_ctrl`

## Requirements
- R1: A software read accepted in one cycle returns the addressed 40-bit entry on `sw_rdata`, with `sw_rvalid` high, in the next cycle. The entry layout is rollback mask in [39:32], use count in [31:16] and failure count in [15:0]. The value read is the last one written.
- R2: An init (`op_code` 1) binds bank `op_bank` to group `op_group` and loads that group's entry into the bank. Operations to that bank are accepted from the second cycle after the init.
- R3: A memory operation (`op_code` 3) with `op_add`=1 records `op_addr` in the named bank. A later check (`op_add`=0) with an equal address drives `rollback` high one cycle later, with `rollback_mask` equal to the bound group's mask. When nothing matches, `rollback` is low and `rollback_mask` is 0.
- R4: An address recorded in one bank never causes a rollback for a check sent to a different bank.
- R5: A clear (`op_code` 2) causes every address recorded before it to stop matching.
- R6: A clear increments the bank's use count. The bank's mask, use count and failure count are written to the bound group's entry on the next clock edge.
- R7: Every check that matches increments the bank's failure count. The new count reaches the table at the bank's next clear.
- R8: The use and failure counts saturate at 0xFFFF.
- R9: Each bank holds 4 addresses between clears. Further adds in the same interval are dropped and never match.
- R10: An operation is ignored and `op_error` pulses one cycle later in any of these cases: it names bank 3; it is a clear or memory operation on an unbound bank; or it targets a bank in the cycle right after that bank's init. An ignored operation never raises `rollback` and causes no write-back.
- R11: `sw_ready` is low only in the cycle after an accepted clear. A software write presented in that cycle is not performed. When held, it completes in the following cycle.
- R12: An init issued in the same cycle as a write to its group's entry loads the newly written value.
- R13: After reset, `rollback`, `op_error` and `sw_rvalid` are low, `sw_ready` is high and no bank is bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 2 | 0 none, 1 init, 2 clear, 3 memory |
| op_bank | input | 2 | Bank identifier |
| op_group | input | 8 | Group table address for init |
| op_add | input | 1 | Memory operation: 1 record, 0 check |
| op_addr | input | 12 | Hashed memory address |
| rollback | output | 1 | Alias detected on last check |
| rollback_mask | output | 8 | Mask of the faulting group |
| op_error | output | 1 | Last operation was ignored |
| sw_req | input | 1 | Software table access |
| sw_we | input | 1 | Software access is a write |
| sw_addr | input | 8 | Software table address |
| sw_wdata | input | 40 | Software write data |
| sw_ready | output | 1 | Software write can be accepted |
| sw_rvalid | output | 1 | Software read data valid |
| sw_rdata | output | 40 | Software read data |

## Verification
On every cycle the assertions check the following. A rollback only ever follows a check operation, and a zero mask goes with the absence of a rollback. Error pulses and rollbacks are never raised together, and an out-of-range bank identifier always produces an error. The software stall appears only after an accepted clear, and read-valid only follows a read request. The bench scenarios alone can show the counting and the binding: which group a bank is bound to, use and failure increments that reach the table, saturation, the drop of a fifth address, ages cleared by a clear, isolation between banks, and forwarding of a fresh entry to an init.

// File: rtl/spq_pkg.sv
package spq_pkg;
  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_INIT  = 2'd1,
    OP_CLEAR = 2'd2,
    OP_MEM   = 2'd3
  } spq_op_e;
endpackage

// File: rtl/spq_info_mem.sv
// Group statistics table: one write port, two registered read ports.
module spq_info_mem #(
  parameter int AW = 8,
  parameter int DW = 40
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          ra_en,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic          rb_en,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (ra_en) ra_data <= mem[ra_addr];
    if (rb_en) rb_data <= mem[rb_addr];
  end
endmodule

// File: rtl/spq_bank.sv
// One alias-check bank: recorded addresses with age bits, plus counters.
module spq_bank #(
  parameter int SLOTS  = 4,
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 16,
  parameter int MASK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  load_use_i,
  input  logic [CNT_W-1:0]  load_fail_i,
  input  logic [MASK_W-1:0] load_mask_i,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic              chk_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [CNT_W-1:0]  use_o,
  output logic [CNT_W-1:0]  use_inc_o,
  output logic [CNT_W-1:0]  fail_o,
  output logic [MASK_W-1:0] mask_o
);
  localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int FW = $clog2(SLOTS + 1);
  localparam logic [FW-1:0] FULL = FW'(SLOTS);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [ADDR_W-1:0] slot_q [SLOTS];
  logic [SLOTS-1:0]  age_q;
  logic [SLOTS-1:0]  match;
  logic [FW-1:0]     fill_q;

  for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
    assign match[i] = age_q[i] && (slot_q[i] == addr_i);
  end

  assign hit_o     = chk_i && (|match);
  assign use_inc_o = (use_o == CMAX) ? use_o : use_o + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      age_q  <= '0;
      fill_q <= '0;
      use_o  <= '0;
      fail_o <= '0;
      mask_o <= '0;
    end else if (load_i) begin
      age_q  <= '0;
      fill_q <= '0;
      use_o  <= load_use_i;
      fail_o <= load_fail_i;
      mask_o <= load_mask_i;
    end else begin
      if (clr_i) begin
        age_q  <= '0;
        fill_q <= '0;
        use_o  <= use_inc_o;
      end
      if (add_i && (fill_q < FULL)) begin
        slot_q[fill_q[IW-1:0]] <= addr_i;
        age_q[fill_q[IW-1:0]]  <= 1'b1;
        fill_q                 <= fill_q + 1'b1;
      end
      if (hit_o && (fail_o != CMAX)) fail_o <= fail_o + 1'b1;
    end
  end
endmodule

// File: rtl/spec_alias_ctrl.sv
module spec_alias_ctrl
  import spq_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int BANK_IDW  = 2,
  parameter int GRP_AW    = 8,
  parameter int MASK_W    = 8,
  parameter int CNT_W     = 16,
  parameter int ADDR_W    = 12,
  parameter int SLOTS     = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        op_valid,
  input  logic [1:0]                  op_code,
  input  logic [BANK_IDW-1:0]         op_bank,
  input  logic [GRP_AW-1:0]           op_group,
  input  logic                        op_add,
  input  logic [ADDR_W-1:0]           op_addr,
  output logic                        rollback,
  output logic [MASK_W-1:0]           rollback_mask,
  output logic                        op_error,
  input  logic                        sw_req,
  input  logic                        sw_we,
  input  logic [GRP_AW-1:0]           sw_addr,
  input  logic [MASK_W+2*CNT_W-1:0]   sw_wdata,
  output logic                        sw_ready,
  output logic                        sw_rvalid,
  output logic [MASK_W+2*CNT_W-1:0]   sw_rdata
);
  localparam int ENT_W  = MASK_W + 2 * CNT_W;
  localparam int NB_PAD = 1 << BANK_IDW;
  localparam logic [BANK_IDW:0] NB_LIM = (BANK_IDW + 1)'(NUM_BANKS);

  logic [NB_PAD-1:0] bound_q;
  logic [GRP_AW-1:0] grp_q [NB_PAD];
  logic [NB_PAD-1:0] hit_v;
  logic [MASK_W-1:0] mask_a [NB_PAD];
  logic [CNT_W-1:0]  use_a [NB_PAD];
  logic [CNT_W-1:0]  use_inc_a [NB_PAD];
  logic [CNT_W-1:0]  fail_a [NB_PAD];

  logic                pend_q;
  logic [BANK_IDW-1:0] pend_bank_q;
  logic                fwd_q;
  logic [ENT_W-1:0]    fwd_data_q;
  logic                wb_q;
  logic [GRP_AW-1:0]   wb_addr_q;
  logic [ENT_W-1:0]    wb_data_q;

  logic              mem_we;
  logic [GRP_AW-1:0] mem_waddr;
  logic [ENT_W-1:0]  mem_wdata;
  logic [ENT_W-1:0]  ra_data;
  logic [ENT_W-1:0]  ld_data;

  logic bank_ok, pend_clash, wants_bound, op_bad, go;
  logic is_init, is_clr, is_mem;

  // Operation decode and admission
  always_comb begin
    bank_ok     = {1'b0, op_bank} < NB_LIM;
    pend_clash  = pend_q && (pend_bank_q == op_bank);
    wants_bound = (op_code == OP_CLEAR) || (op_code == OP_MEM);
    op_bad      = op_valid && (op_code != OP_NOP) &&
                  (!bank_ok || pend_clash || (wants_bound && !bound_q[op_bank]));
    go          = op_valid && (op_code != OP_NOP) && !op_bad;
    is_init     = go && (op_code == OP_INIT);
    is_clr      = go && (op_code == OP_CLEAR);
    is_mem      = go && (op_code == OP_MEM);
  end

  // Single write port: write-back wins, software writes wait
  always_comb begin
    mem_we    = wb_q || (sw_req && sw_we);
    mem_waddr = wb_q ? wb_addr_q : sw_addr;
    mem_wdata = wb_q ? wb_data_q : sw_wdata;
  end

  assign sw_ready = !wb_q;
  assign ld_data  = fwd_q ? fwd_data_q : ra_data;

  spq_info_mem #(.AW(GRP_AW), .DW(ENT_W)) u_info (
    .clk     (clk),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (mem_wdata),
    .ra_en   (is_init),
    .ra_addr (op_group),
    .ra_data (ra_data),
    .rb_en   (sw_req && !sw_we),
    .rb_addr (sw_addr),
    .rb_data (sw_rdata)
  );

  for (genvar i = 0; i < NB_PAD; i++) begin : g_bank
    if (i < NUM_BANKS) begin : g_live
      logic sel;
      assign sel = (op_bank == BANK_IDW'(i));
      spq_bank #(
        .SLOTS(SLOTS), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MASK_W(MASK_W)
      ) u_bank (
        .clk         (clk),
        .rst         (rst),
        .load_i      (pend_q && (pend_bank_q == BANK_IDW'(i))),
        .load_use_i  (ld_data[2*CNT_W-1:CNT_W]),
        .load_fail_i (ld_data[CNT_W-1:0]),
        .load_mask_i (ld_data[ENT_W-1:2*CNT_W]),
        .clr_i       (is_clr && sel),
        .add_i       (is_mem && sel && op_add),
        .chk_i       (is_mem && sel && !op_add),
        .addr_i      (op_addr),
        .hit_o       (hit_v[i]),
        .use_o       (use_a[i]),
        .use_inc_o   (use_inc_a[i]),
        .fail_o      (fail_a[i]),
        .mask_o      (mask_a[i])
      );
    end else begin : g_pad
      assign hit_v[i]     = 1'b0;
      assign mask_a[i]    = '0;
      assign use_a[i]     = '0;
      assign use_inc_a[i] = '0;
      assign fail_a[i]    = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bound_q       <= '0;
      pend_q        <= 1'b0;
      fwd_q         <= 1'b0;
      wb_q          <= 1'b0;
      rollback      <= 1'b0;
      rollback_mask <= '0;
      op_error      <= 1'b0;
      sw_rvalid     <= 1'b0;
    end else begin
      pend_q      <= is_init;
      pend_bank_q <= op_bank;
      fwd_q       <= is_init && mem_we && (mem_waddr == op_group);
      fwd_data_q  <= mem_wdata;
      if (is_init) begin
        bound_q[op_bank] <= 1'b1;
        grp_q[op_bank]   <= op_group;
      end
      wb_q          <= is_clr;
      wb_addr_q     <= grp_q[op_bank];
      wb_data_q     <= {mask_a[op_bank], use_inc_a[op_bank], fail_a[op_bank]};
      rollback      <= |hit_v;
      rollback_mask <= (|hit_v) ? mask_a[op_bank] : '0;
      op_error      <= op_bad;
      sw_rvalid     <= sw_req && !sw_we;
    end
  end
endmodule

// File: rtl/spec_alias_ctrl_chk.sv
module spec_alias_ctrl_chk #(
  parameter int NUM_BANKS = 3,
  parameter int BANK_IDW  = 2,
  parameter int MASK_W    = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                op_valid,
  input logic [1:0]          op_code,
  input logic [BANK_IDW-1:0] op_bank,
  input logic                op_add,
  input logic                rollback,
  input logic [MASK_W-1:0]   rollback_mask,
  input logic                op_error,
  input logic                sw_req,
  input logic                sw_we,
  input logic                sw_ready,
  input logic                sw_rvalid
);
  localparam logic [BANK_IDW:0] NB_LIM = (BANK_IDW + 1)'(NUM_BANKS);

  assert_rb_after_check_R3: assert property (@(posedge clk) disable iff (rst)
    rollback |-> $past(op_valid && (op_code == 2'd3) && !op_add));

  assert_mask_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !rollback |-> (rollback_mask == '0));

  assert_err_excl_R10: assert property (@(posedge clk) disable iff (rst)
    op_error |-> !rollback);

  assert_bad_id_R10: assert property (@(posedge clk) disable iff (rst)
    $past(op_valid && (op_code != 2'd0) && ({1'b0, op_bank} >= NB_LIM)) |-> op_error);

  assert_stall_src_R11: assert property (@(posedge clk) disable iff (rst)
    !sw_ready |-> ($past(op_valid && (op_code == 2'd2)) && !op_error));

  assert_rvalid_src_R1: assert property (@(posedge clk) disable iff (rst)
    sw_rvalid |-> $past(sw_req && !sw_we));
endmodule

bind spec_alias_ctrl spec_alias_ctrl_chk #(
  .NUM_BANKS(NUM_BANKS), .BANK_IDW(BANK_IDW), .MASK_W(MASK_W)
) u_chk (.*);

// File: tb/spec_alias_ctrl_test.sv
module spec_alias_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [1:0]  op_code = 2'd0;
  logic [1:0]  op_bank = 2'd0;
  logic [7:0]  op_group = 8'd0;
  logic        op_add = 1'b0;
  logic [11:0] op_addr = 12'd0;
  logic        rollback;
  logic [7:0]  rollback_mask;
  logic        op_error;
  logic        sw_req = 1'b0;
  logic        sw_we = 1'b0;
  logic [7:0]  sw_addr = 8'd0;
  logic [39:0] sw_wdata = 40'd0;
  logic        sw_ready;
  logic        sw_rvalid;
  logic [39:0] sw_rdata;

  int n_checks = 0;
  int n_err = 0;
  logic [39:0] model [256];
  logic        got_rb, got_err, got_rdy;
  logic [7:0]  got_mask;
  logic [39:0] rd;
  logic [7:0]  gb [3];
  int          hits [3];

  always #5 clk = ~clk;

  spec_alias_ctrl uut (.*);

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] c, input logic [1:0] b, input logic [7:0] g,
                       input logic a, input logic [11:0] ad);
    op_valid = (c != 2'd0); op_code = c; op_bank = b; op_group = g; op_add = a; op_addr = ad;
    @(negedge clk);
    op_valid = 1'b0; op_code = 2'd0;
    got_rb = rollback; got_mask = rollback_mask; got_err = op_error; got_rdy = sw_ready;
  endtask

  task automatic sw_write(input logic [7:0] a, input logic [39:0] d);
    sw_req = 1'b1; sw_we = 1'b1; sw_addr = a; sw_wdata = d;
    while (!sw_ready) @(negedge clk);
    @(negedge clk);
    sw_req = 1'b0; sw_we = 1'b0;
    model[a] = d;
  endtask

  task automatic sw_read(input logic [7:0] a, output logic [39:0] d);
    sw_req = 1'b1; sw_we = 1'b0; sw_addr = a;
    @(negedge clk);
    sw_req = 1'b0;
    check("R1 rvalid", {39'd0, sw_rvalid}, 40'd1);
    d = sw_rdata;
  endtask

  function automatic logic [15:0] sat_add(input logic [15:0] v, input int n);
    int s;
    s = int'(v) + n;
    return (s > 65535) ? 16'hFFFF : 16'(s);
  endfunction

  function automatic logic [11:0] addr_of(input int b, input int k);
    return 12'(b * 64 + k * 3 + 1);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R13 reset state
    check("R13 rollback", {39'd0, rollback}, 40'd0);
    check("R13 op_error", {39'd0, op_error}, 40'd0);
    check("R13 sw_rvalid", {39'd0, sw_rvalid}, 40'd0);
    check("R13 sw_ready", {39'd0, sw_ready}, 40'd1);
    // R10 / R13: unbound bank after reset
    do_op(2'd2, 2'd1, 8'd0, 1'b0, 12'd0);
    check("R10 clear unbound err", {39'd0, got_err}, 40'd1);
    check("R10 clear unbound no writeback", {39'd0, got_rdy}, 40'd1);
    do_op(2'd3, 2'd0, 8'd0, 1'b0, 12'd5);
    check("R10 mem unbound err", {39'd0, got_err}, 40'd1);
    check("R10 no rollback", {39'd0, got_rb}, 40'd0);
    do_op(2'd0, 2'd0, 8'd0, 1'b0, 12'd0);
    check("R10 error is a pulse", {39'd0, got_err}, 40'd0);

    // R1 sweep of the table
    for (int g = 0; g < 256; g++)
      sw_write(8'(g), {8'(g) ^ 8'hA5, 16'(g * 37), 16'(g * 5)});
    for (int g = 0; g < 256; g++) begin
      sw_read(8'(g), rd);
      check("R1 table readback", rd, model[g]);
    end

    // R2 bind all three banks back to back
    for (int b = 0; b < 3; b++) begin
      gb[b] = 8'(20 + b * 9);
      hits[b] = 0;
      do_op(2'd1, 2'(b), gb[b], 1'b0, 12'd0);
      check("R2 init accepted", {39'd0, got_err}, 40'd0);
    end
    do_op(2'd0, 2'd0, 8'd0, 1'b0, 12'd0);
    // R3 record addresses
    for (int b = 0; b < 3; b++)
      for (int k = 0; k < 4; k++) begin
        do_op(2'd3, 2'(b), 8'd0, 1'b1, addr_of(b, k));
        check("R3 add no rollback", {31'd0, got_err, got_rb, got_mask}, 40'd0);
      end
    // R9 fifth address on bank 0 is dropped
    do_op(2'd3, 2'd0, 8'd0, 1'b1, 12'd50);
    do_op(2'd3, 2'd0, 8'd0, 1'b0, 12'd50);
    check("R9 dropped address no match", {39'd0, got_rb}, 40'd0);
    // R3/R4 cross sweep
    for (int b = 0; b < 3; b++)
      for (int s = 0; s < 3; s++)
        for (int k = 0; k < 4; k++) begin
          do_op(2'd3, 2'(b), 8'd0, 1'b0, addr_of(s, k));
          if (s == b) begin
            hits[b]++;
            check("R3 hit rollback", {39'd0, got_rb}, 40'd1);
            check("R3 hit mask", {32'd0, got_mask}, {32'd0, model[gb[b]][39:32]});
          end else begin
            check("R4 other bank no rollback", {31'd0, got_rb, got_mask}, 40'd0);
          end
        end
    // R6/R7 clear and write back
    for (int b = 0; b < 3; b++) begin
      do_op(2'd2, 2'(b), 8'd0, 1'b0, 12'd0);
      check("R11 stall after clear", {39'd0, got_rdy}, 40'd0);
      do_op(2'd0, 2'd0, 8'd0, 1'b0, 12'd0);
      check("R11 ready again", {39'd0, got_rdy}, 40'd1);
      model[gb[b]] = {model[gb[b]][39:32], sat_add(model[gb[b]][31:16], 1),
                      sat_add(model[gb[b]][15:0], hits[b])};
      sw_read(gb[b], rd);
      check("R6 R7 write back", rd, model[gb[b]]);
      // R5 ages cleared
      do_op(2'd3, 2'(b), 8'd0, 1'b0, addr_of(b, 0));
      check("R5 no match after clear", {39'd0, got_rb}, 40'd0);
    end

    // R10 bank id 3 and pending bank
    do_op(2'd3, 2'd3, 8'd0, 1'b1, 12'd7);
    check("R10 bank 3 err", {39'd0, got_err}, 40'd1);
    do_op(2'd1, 2'd3, 8'd9, 1'b0, 12'd0);
    check("R10 init bank 3 err", {39'd0, got_err}, 40'd1);
    do_op(2'd1, 2'd0, 8'd40, 1'b0, 12'd0);
    do_op(2'd3, 2'd0, 8'd0, 1'b1, 12'd99);
    check("R2 R10 op in load cycle err", {39'd0, got_err}, 40'd1);
    do_op(2'd3, 2'd0, 8'd0, 1'b0, 12'd99);
    check("R10 ignored add left no address", {39'd0, got_rb}, 40'd0);
    check("R2 bank usable after load", {39'd0, got_err}, 40'd0);

    // R8 saturation
    sw_write(8'd200, {8'h3C, 16'hFFFF, 16'hFFFF});
    do_op(2'd1, 2'd2, 8'd200, 1'b0, 12'd0);
    do_op(2'd0, 2'd0, 8'd0, 1'b0, 12'd0);
    do_op(2'd3, 2'd2, 8'd0, 1'b1, 12'd300);
    do_op(2'd3, 2'd2, 8'd0, 1'b0, 12'd300);
    check("R8 R3 mask of loaded group", {31'd0, got_rb, got_mask}, {31'd0, 1'b1, 8'h3C});
    do_op(2'd2, 2'd2, 8'd0, 1'b0, 12'd0);
    do_op(2'd0, 2'd0, 8'd0, 1'b0, 12'd0);
    sw_read(8'd200, rd);
    check("R8 saturated counts", rd, {8'h3C, 16'hFFFF, 16'hFFFF});

    // R12 forwarding of a fresh write-back to init; R11 held write
    do_op(2'd1, 2'd0, 8'd77, 1'b0, 12'd0);
    do_op(2'd0, 2'd0, 8'd0, 1'b0, 12'd0);
    do_op(2'd2, 2'd0, 8'd0, 1'b0, 12'd0);
    do_op(2'd1, 2'd1, 8'd77, 1'b0, 12'd0);
    do_op(2'd0, 2'd0, 8'd0, 1'b0, 12'd0);
    do_op(2'd2, 2'd1, 8'd0, 1'b0, 12'd0);
    check("R11 ready low after clear", {39'd0, got_rdy}, 40'd0);
    sw_write(8'd5, 40'h12_3456_789A);
    model[77] = {model[77][39:32], sat_add(model[77][31:16], 2), model[77][15:0]};
    sw_read(8'd77, rd);
    check("R12 forwarded entry", rd, model[77]);
    sw_read(8'd5, rd);
    check("R11 held write landed", rd, 40'h12_3456_789A);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule